// File: doc/BRIEF.md
# I2C Slave Controller with Host-Controlled Clock Stretching

This block is the target side of a two-wire serial bus, managed by a host through a small 16-bit register window. It samples the open-drain clock and data lines through synchronizers and glitch filters. It recognises START, repeated START and STOP, and compares incoming address bytes with its own address in either 7-bit or 10-bit form. It answers a matching address by pulling data low in the acknowledge slot.

Every byte it accepts, whether address or data, goes from a shift register into a separate receive holding register. After the acknowledge clock the block holds the clock line low until the host writes a release command. While the clock is held, the host reads the received byte or loads the next byte to send. A one-cycle interrupt pulse marks each hold. If a byte completes while the holding register still has unread data, the block refuses that byte and raises an overflow flag. On a read transfer the block shifts the transmit register out MSB first and stops when the bus controller answers with NACK.

Top module: `i2c_slv_ctl`

## Requirements
- R1: After reset, the control, status, receive and transmit registers read 0, and `scl_oe` and `sda_oe` are 0.
- R2: Status bit 3 is set by a START or repeated START and cleared by a STOP. Status bit 4 is set by a STOP and cleared by a START.
- R3: With control bit 1 = 0, an address byte is ACKed (SDA low in the 9th clock) only when bits 7:1 equal own-address register bits 6:0. A non-matching byte is NACKed, gives no interrupt and does not hold SCL.
- R4: With control bit 1 = 1, a first byte 11110 a9 a8 0 is ACKed only if a9 a8 equal own-address bits 9:8. The next byte is ACKed only if it equals own-address bits 7:0.
- R5: In 10-bit mode, a first byte 11110 a9 a8 1 is ACKed only if a full 10-bit write-phase match happened since the last STOP. A repeated START is enough; the low address byte is not needed again.
- R6: Each ACKed received byte, address or data, appears in register 2 and sets status bit 0. Reading register 2 clears status bit 0. Status bit 2 is 1 for a data byte and 0 for an address byte.
- R7: A byte that completes while status bit 0 is 1 is NACKed, sets status bit 6 and leaves register 2 unchanged. Status bit 6 is host-writable, so writing 0 clears it.
- R8: After the 9th-clock falling edge of every ACKed byte, including transmitted bytes the bus controller ACKs, `scl_oe` stays 1 and status bit 5 reads 1. Both remain until the host writes register 0 with bit 2 = 1.
- R9: After an ACKed address with R/W = 1 and a release, the block sends transmit register bits 7:0 MSB first. Status bit 1 reads 1 during the transfer. A NACK from the bus controller leaves SDA and SCL released, with no hold.
- R10: `irq` is a single-cycle pulse, given once per clock hold as the hold begins.
- R11: Status bits 5:0 ignore host writes.
- R12: While control bit 0 = 0, the block never drives SDA or SCL and never ACKs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (reading register 2 clears the full flag) |
| reg_addr | input | 3 | Register select: 0 control, 1 status, 2 receive, 3 transmit, 4 own address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, combinational from `reg_addr` |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Slave-event interrupt pulse |

## Verification
The bench goes after the 10-bit read header in three settings: with no earlier match, after a full match plus repeated START, and after a STOP. A design that kept the match flag across STOP, or never set it, would ACK or NACK the wrong one. The bench fills the receive register and then sends another byte. A design without the overflow check would ACK that byte and overwrite the unread data. Other checks confirm that the clock hold survives a long host delay, and that a NACK on the last transmitted byte produces no hold. A design that stretched unconditionally would freeze the bus before STOP.

// File: rtl/i2c_slv_pkg.sv
`timescale 1ns/1ps
// Shared types and register map for the I2C slave controller.
// Assumes a 3-bit host register select.
package i2c_slv_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_ACKW, S_HOLDF, S_STRETCH, S_TX, S_TXACK, S_WSTOP
    } eng_state_t;

    typedef enum logic [1:0] {K_ADDR1, K_ADDR2, K_DATA} byte_kind_t;

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_STAT = 3'd1;
    localparam logic [2:0] REG_RXD  = 3'd2;
    localparam logic [2:0] REG_TXD  = 3'd3;
    localparam logic [2:0] REG_OWN  = 3'd4;

    localparam int ST_RXF  = 0;
    localparam int ST_RW   = 1;
    localparam int ST_DATA = 2;
    localparam int ST_STRT = 3;
    localparam int ST_STOP = 4;
    localparam int ST_HOLD = 5;
    localparam int ST_OVF  = 6;

    localparam int CT_EN   = 0;
    localparam int CT_TEN  = 1;
    localparam int CT_REL  = 2;
endpackage

// File: rtl/i2c_slv_line_filt.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus stability filter for one bus line.
// The output follows the input only after FILT_LEN consecutive equal samples.
// Assumes the idle line level is high.
module i2c_slv_line_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw};
    end

    // Accept a new level only after it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b1;
            cnt_q <= '0;
        end else if (sync_q[1] == clean) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            clean <= sync_q[1];
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_slv_bus_cond.sv
`timescale 1ns/1ps
// Edge and bus-condition detector on filtered SCL/SDA.
// START is SDA falling while SCL is high; STOP is SDA rising while SCL is high.
// Assumes the inputs are already synchronized and filtered.
module i2c_slv_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode single-cycle events from level changes.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_slv_engine.sv
`timescale 1ns/1ps
// Byte-level slave protocol engine: address match (7/10-bit), receive
// shifting, ACK generation, transmit shifting and clock hold after each byte.
// Assumes single-cycle event pulses from i2c_slv_bus_cond and a release pulse
// from the host. A low en holds the engine idle.
module i2c_slv_engine
    import i2c_slv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       ten_bit,
    input  logic [9:0] own_addr,
    input  logic [7:0] tx_data,
    input  logic       rx_full,
    input  logic       release_cmd,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_f,
    output logic       sda_oe,
    output logic       scl_oe,
    output logic       rx_load,
    output logic [7:0] rx_byte,
    output logic       rx_is_data,
    output logic       ovf_pulse,
    output logic       irq,
    output logic       reading,
    output logic       stretching,
    output logic       start_seen,
    output logic       stop_seen
);
    eng_state_t state_q;
    byte_kind_t kind_q, kind_c;
    logic [3:0] bitcnt_q;
    logic [6:0] shreg_q;
    logic [7:0] tsh_q;
    logic [7:0] byte_c;
    logic       ack_q, tenbit_hit_q;
    logic       hit_c, rd_c;

    // Match the completed byte against the own address for its position.
    always_comb begin
        byte_c = {shreg_q, sda_f};
        hit_c  = 1'b0;
        rd_c   = reading;
        kind_c = K_DATA;
        case (kind_q)
            K_ADDR1: begin
                if (!ten_bit) begin
                    hit_c = (byte_c[7:1] == own_addr[6:0]);
                    rd_c  = byte_c[0];
                end else if (!byte_c[0]) begin
                    hit_c  = (byte_c[7:3] == 5'b11110) && (byte_c[2:1] == own_addr[9:8]);
                    rd_c   = 1'b0;
                    kind_c = K_ADDR2;
                end else begin
                    hit_c = (byte_c[7:3] == 5'b11110) && (byte_c[2:1] == own_addr[9:8])
                            && tenbit_hit_q;
                    rd_c  = 1'b1;
                end
            end
            K_ADDR2: hit_c = (byte_c == own_addr[7:0]);
            default: hit_c = 1'b1;
        endcase
    end

    assign stretching = (state_q == S_STRETCH);

    // Protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q      <= S_IDLE;
            kind_q       <= K_ADDR1;
            bitcnt_q     <= '0;
            shreg_q      <= '0;
            tsh_q        <= '0;
            ack_q        <= 1'b0;
            tenbit_hit_q <= 1'b0;
            sda_oe       <= 1'b0;
            scl_oe       <= 1'b0;
            rx_load      <= 1'b0;
            rx_byte      <= '0;
            rx_is_data   <= 1'b0;
            ovf_pulse    <= 1'b0;
            irq          <= 1'b0;
            reading      <= 1'b0;
            start_seen   <= 1'b0;
            stop_seen    <= 1'b0;
        end else begin
            rx_load   <= 1'b0;
            ovf_pulse <= 1'b0;
            irq       <= 1'b0;
            if (start_det) begin
                state_q    <= S_RX;
                kind_q     <= K_ADDR1;
                bitcnt_q   <= '0;
                sda_oe     <= 1'b0;
                scl_oe     <= 1'b0;
                reading    <= 1'b0;
                start_seen <= 1'b1;
                stop_seen  <= 1'b0;
            end else if (stop_det) begin
                state_q      <= S_IDLE;
                sda_oe       <= 1'b0;
                scl_oe       <= 1'b0;
                reading      <= 1'b0;
                tenbit_hit_q <= 1'b0;
                start_seen   <= 1'b0;
                stop_seen    <= 1'b1;
            end else begin
                case (state_q)
                    S_RX: if (scl_rise) begin
                        shreg_q <= byte_c[6:0];
                        if (bitcnt_q == 4'd7) begin
                            ack_q      <= hit_c && !rx_full;
                            rx_load    <= hit_c && !rx_full;
                            ovf_pulse  <= hit_c && rx_full;
                            rx_byte    <= byte_c;
                            rx_is_data <= (kind_q == K_DATA);
                            if (hit_c && !rx_full) begin
                                kind_q  <= kind_c;
                                reading <= rd_c;
                                if (kind_q == K_ADDR1 && ten_bit && !byte_c[0])
                                    tenbit_hit_q <= 1'b0;
                                if (kind_q == K_ADDR2)
                                    tenbit_hit_q <= 1'b1;
                            end
                            state_q <= S_ACKW;
                        end else begin
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                    S_ACKW: if (scl_fall) begin
                        sda_oe  <= ack_q;
                        state_q <= ack_q ? S_HOLDF : S_WSTOP;
                    end
                    S_HOLDF: if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        scl_oe  <= 1'b1;
                        irq     <= 1'b1;
                        state_q <= S_STRETCH;
                    end
                    S_STRETCH: if (release_cmd) begin
                        scl_oe   <= 1'b0;
                        bitcnt_q <= '0;
                        if (reading) begin
                            tsh_q   <= tx_data;
                            sda_oe  <= ~tx_data[7];
                            state_q <= S_TX;
                        end else begin
                            state_q <= S_RX;
                        end
                    end
                    S_TX: begin
                        if (scl_rise) begin
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt_q == 4'd8) begin
                                sda_oe  <= 1'b0;
                                state_q <= S_TXACK;
                            end else begin
                                sda_oe <= ~tsh_q[3'd7 - bitcnt_q[2:0]];
                            end
                        end
                    end
                    S_TXACK: if (scl_rise) begin
                        state_q <= sda_f ? S_WSTOP : S_HOLDF;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_slv_ctl.sv
`timescale 1ns/1ps
// Top of the I2C slave controller: host register window, line filters,
// bus-condition detector and protocol engine.
// Assumes reg_addr/wdata are valid with their strobes; rdata is combinational.
module i2c_slv_ctl
    import i2c_slv_pkg::*;
#(
    parameter int DW       = 16,
    parameter int RAW      = 3,
    parameter int FILT_LEN = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic           scl_i,
    input  logic           sda_i,
    output logic           scl_oe,
    output logic           sda_oe,
    output logic           irq
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_bus, filt_bus;
    logic scl_rise, scl_fall, start_det, stop_det;

    logic          ctrl_en, ctrl_ten, rel_pulse;
    logic [DW-1:0] own_q;
    logic [7:0]    txd_q, rxd_q;
    logic          rx_full, rx_data_q, ovf_q;

    logic       eng_rx_load, eng_ovf, eng_is_data, eng_reading;
    logic       eng_stretch, eng_start, eng_stop;
    logic [7:0] eng_rx_byte;

    assign raw_bus = {scl_i, sda_i};

    // One filter per bus line: index 1 is SCL, index 0 is SDA.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_slv_line_filt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_bus[g]),
            .clean (filt_bus[g])
        );
    end

    i2c_slv_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_bus[1]),
        .sda_f     (filt_bus[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slv_engine u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl_en),
        .ten_bit     (ctrl_ten),
        .own_addr    (own_q[9:0]),
        .tx_data     (txd_q),
        .rx_full     (rx_full),
        .release_cmd (rel_pulse),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .sda_f       (filt_bus[0]),
        .sda_oe      (sda_oe),
        .scl_oe      (scl_oe),
        .rx_load     (eng_rx_load),
        .rx_byte     (eng_rx_byte),
        .rx_is_data  (eng_is_data),
        .ovf_pulse   (eng_ovf),
        .irq         (irq),
        .reading     (eng_reading),
        .stretching  (eng_stretch),
        .start_seen  (eng_start),
        .stop_seen   (eng_stop)
    );

    // Host-writable control, address and transmit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_ten  <= 1'b0;
            rel_pulse <= 1'b0;
            own_q     <= '0;
            txd_q     <= '0;
        end else begin
            rel_pulse <= 1'b0;
            if (wr_en) begin
                case (reg_addr)
                    REG_CTRL: begin
                        ctrl_en   <= wdata[CT_EN];
                        ctrl_ten  <= wdata[CT_TEN];
                        rel_pulse <= wdata[CT_REL];
                    end
                    REG_TXD: txd_q <= wdata[7:0];
                    REG_OWN: own_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Receive holding register, full flag and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_q     <= '0;
            rx_full   <= 1'b0;
            rx_data_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            if (eng_rx_load) begin
                rxd_q     <= eng_rx_byte;
                rx_full   <= 1'b1;
                rx_data_q <= eng_is_data;
            end else if (rd_en && reg_addr == REG_RXD) begin
                rx_full <= 1'b0;
            end
            if (eng_ovf)
                ovf_q <= 1'b1;
            else if (wr_en && reg_addr == REG_STAT)
                ovf_q <= wdata[ST_OVF];
        end
    end

    // Register read multiplexer.
    always_comb begin
        rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                rdata[CT_EN]  = ctrl_en;
                rdata[CT_TEN] = ctrl_ten;
            end
            REG_STAT: begin
                rdata[ST_RXF]  = rx_full;
                rdata[ST_RW]   = eng_reading;
                rdata[ST_DATA] = rx_data_q;
                rdata[ST_STRT] = eng_start;
                rdata[ST_STOP] = eng_stop;
                rdata[ST_HOLD] = eng_stretch;
                rdata[ST_OVF]  = ovf_q;
            end
            REG_RXD: rdata[7:0] = rxd_q;
            REG_TXD: rdata[7:0] = txd_q;
            REG_OWN: rdata      = own_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_slv_ctl_chk.sv
`timescale 1ns/1ps
// Property checker for i2c_slv_ctl, attached with bind below.
module i2c_slv_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_oe,
    input logic sda_oe,
    input logic irq,
    input logic rel_pulse,
    input logic rx_load,
    input logic ovf_pulse,
    input logic rx_full
);
    // R8: a clock hold persists until the host release arrives
    a_r8_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !rel_pulse && en) |=> scl_oe);

    // R10: the interrupt is a single-cycle pulse
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: the interrupt marks the start of a clock hold
    a_r10_irq_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> scl_oe);

    // R12: a disabled block releases both lines
    a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_oe && !sda_oe));

    // R6: loading a byte sets the full flag
    a_r6_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> rx_full);

    // R7: overflow is raised only against a full buffer
    a_r7_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(rx_full));
endmodule

bind i2c_slv_ctl i2c_slv_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_en),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .irq       (irq),
    .rel_pulse (rel_pulse),
    .rx_load   (eng_rx_load),
    .ovf_pulse (eng_ovf),
    .rx_full   (rx_full)
);

// File: tb/i2c_slv_ctl_tb.sv
`timescale 1ns/1ps
module i2c_slv_ctl_tb;
    localparam int H = 25;
    localparam int Q = 8;
    // {address byte, data byte, expected ACK} in 7-bit mode, own address 0x2A
    localparam logic [16:0] VEC [0:5] = '{
        {8'h54, 8'h3C, 1'b1},
        {8'h56, 8'h00, 1'b0},
        {8'h54, 8'hFF, 1'b1},
        {8'hD4, 8'h11, 1'b0},
        {8'h54, 8'h00, 1'b1},
        {8'h14, 8'h77, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic scl_oe, sda_oe, irq;
    logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
    logic scl, sda;
    int tests = 0, fails = 0, irq_cnt = 0;
    bit done = 1'b0;

    assign scl = !(m_scl_lo || scl_oe);
    assign sda = !(m_sda_lo || sda_oe);

    always #10 clk = ~clk;

    always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

    i2c_slv_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata),
        .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic scl_hi();
        m_scl_lo = 1'b0;
        do @(negedge clk); while (!scl);
    endtask

    task automatic m_start();
        wclk(Q); m_sda_lo = 1'b0; wclk(H);
        scl_hi(); wclk(H);
        m_sda_lo = 1'b1; wclk(H);
        m_scl_lo = 1'b1; wclk(H);
    endtask

    task automatic m_stop();
        wclk(Q); m_sda_lo = 1'b1; wclk(H);
        scl_hi(); wclk(H);
        m_sda_lo = 1'b0; wclk(H);
    endtask

    task automatic m_write(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wclk(Q); m_sda_lo = !b[i]; wclk(H);
            scl_hi(); wclk(H);
            m_scl_lo = 1'b1;
        end
        wclk(Q); m_sda_lo = 1'b0; wclk(H);
        scl_hi(); wclk(H / 2);
        ack = !sda;
        wclk(H / 2); m_scl_lo = 1'b1; wclk(H);
    endtask

    task automatic m_read(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wclk(Q); m_sda_lo = 1'b0; wclk(H);
            scl_hi(); wclk(H / 2);
            b[i] = sda;
            wclk(H / 2); m_scl_lo = 1'b1;
        end
        wclk(Q); m_sda_lo = give_ack; wclk(H);
        scl_hi(); wclk(H);
        m_scl_lo = 1'b1; wclk(Q);
        m_sda_lo = 1'b0; wclk(H);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [16:0] v;
        logic ack;
        logic [7:0] rb;
        int ic;

        wclk(5); rst_n = 1'b1; wclk(2);
        // R1 reset state
        reg_rd(3'd1, d); chk("R1 status", d, 0);
        reg_rd(3'd0, d); chk("R1 control", d, 0);
        reg_rd(3'd2, d); chk("R1 rx", d, 0);
        reg_rd(3'd3, d); chk("R1 tx", d, 0);
        chk("R1 line drive", {scl_oe, sda_oe}, 0);

        // R12 disabled: no ACK
        reg_wr(3'd4, 16'h002A);
        m_start(); m_write(8'h54, ack); chk("R12 no ack when off", ack, 0);
        m_stop();
        chk("R12 no irq", irq_cnt, 0);

        reg_wr(3'd0, 16'h0001);
        // Table of 7-bit write transfers: R3 R6 R8 R10 R2
        for (int i = 0; i < 6; i++) begin
            v = VEC[i];
            ic = irq_cnt;
            m_start();
            m_write(v[16:9], ack);
            chk("R3 address ack", ack, v[0]);
            wclk(40);
            if (v[0]) begin
                chk("R10 irq on hold", irq_cnt, ic + 1);
                reg_rd(3'd1, d); chk("R6 R8 R2 status after address", d, 16'h29);
                reg_rd(3'd2, d); chk("R6 rx address byte", d, v[16:9]);
                reg_wr(3'd0, 16'h0005);
                m_write(v[8:1], ack); chk("R6 data ack", ack, 1);
                wclk(40);
                reg_rd(3'd1, d); chk("R6 status data flag", d, 16'h2D);
                reg_rd(3'd2, d); chk("R6 rx data byte", d, v[8:1]);
                reg_wr(3'd0, 16'h0005);
            end else begin
                chk("R3 no irq on mismatch", irq_cnt, ic);
                chk("R3 no hold on mismatch", scl_oe, 0);
            end
            m_stop(); wclk(10);
            reg_rd(3'd1, d); chk("R2 stop flag", d[4:3], 2'b10);
        end

        // R11 read-only low status bits, R7 overflow bit writable
        reg_rd(3'd1, d); ic = d;
        reg_wr(3'd1, 16'h003F); reg_rd(3'd1, d); chk("R11 low bits ignore write", d, ic);
        reg_wr(3'd1, 16'h0040); reg_rd(3'd1, d); chk("R7 ovf writable", d[6], 1);
        reg_wr(3'd1, 16'h0000); reg_rd(3'd1, d); chk("R7 ovf cleared", d[6], 0);

        // R7 overflow: do not read the address byte, send a data byte
        m_start(); m_write(8'h54, ack); chk("R7 address ack", ack, 1);
        ic = irq_cnt;
        reg_wr(3'd0, 16'h0005);
        m_write(8'hAA, ack); chk("R7 data nack on full", ack, 0);
        wclk(20);
        reg_rd(3'd1, d); chk("R7 ovf set", d[6], 1);
        chk("R7 no irq", irq_cnt, ic);
        m_stop();
        reg_rd(3'd2, d); chk("R7 rx unchanged", d, 16'h54);
        reg_wr(3'd1, 16'h0000);

        // R8 hold survives a long host delay
        m_start(); m_write(8'h54, ack);
        wclk(300); chk("R8 hold persists", scl_oe, 1);
        reg_rd(3'd2, d);
        reg_wr(3'd0, 16'h0005); wclk(3); chk("R8 hold released", scl_oe, 0);
        m_stop();

        // R9 read transfer
        m_start(); m_write(8'h55, ack); chk("R9 read address ack", ack, 1);
        wclk(40);
        reg_rd(3'd1, d); chk("R9 R11 rw status", d, 16'h2B);
        reg_rd(3'd2, d);
        reg_wr(3'd3, 16'h00A5); reg_wr(3'd0, 16'h0005);
        ic = irq_cnt;
        m_read(1'b1, rb); chk("R9 first tx byte", rb, 8'hA5);
        wclk(40);
        chk("R8 hold after acked tx byte", scl_oe, 1);
        chk("R10 irq after tx byte", irq_cnt, ic + 1);
        reg_wr(3'd3, 16'h003C); reg_wr(3'd0, 16'h0005);
        m_read(1'b0, rb); chk("R9 second tx byte", rb, 8'h3C);
        wclk(100);
        chk("R9 no hold after nack", {scl_oe, sda_oe}, 0);
        m_stop();

        // 10-bit mode, own address 0x2A5
        reg_wr(3'd4, 16'h02A5); reg_wr(3'd0, 16'h0003);
        m_start(); m_write(8'hF5, ack); chk("R5 read header without match", ack, 0); m_stop();
        m_start(); m_write(8'hF2, ack); chk("R4 wrong high bits", ack, 0); m_stop();
        m_start(); m_write(8'hF4, ack); chk("R4 header ack", ack, 1);
        reg_rd(3'd2, d); reg_wr(3'd0, 16'h0007);
        m_write(8'hA4, ack); chk("R4 wrong low byte", ack, 0); m_stop();

        m_start(); m_write(8'hF4, ack); chk("R4 header ack full", ack, 1);
        reg_rd(3'd2, d); reg_wr(3'd0, 16'h0007);
        m_write(8'hA5, ack); chk("R4 low byte ack", ack, 1);
        reg_rd(3'd2, d); chk("R6 10-bit low byte held", d, 16'hA5);
        reg_wr(3'd0, 16'h0007);
        m_write(8'h5A, ack); chk("R4 data ack", ack, 1);
        reg_rd(3'd2, d); reg_wr(3'd0, 16'h0007);
        m_start(); m_write(8'hF5, ack); chk("R5 read header after restart", ack, 1);
        wclk(40);
        reg_rd(3'd1, d); chk("R5 R2 status after restart", d, 16'h2B);
        reg_rd(3'd2, d);
        reg_wr(3'd3, 16'h00C3); reg_wr(3'd0, 16'h0007);
        m_read(1'b0, rb); chk("R9 10-bit tx byte", rb, 8'hC3);
        m_stop();
        m_start(); m_write(8'hF5, ack); chk("R5 match cleared by stop", ack, 0); m_stop();

        done = 1'b1;
        report();
        $finish;
    end
endmodule